// File: doc/BRIEF.md
# Sigma-Delta Decimation Conversion Controller

This block sits behind a one-bit sigma-delta modulator and turns its oversampled bitstream into 16-bit conversion words. A third-order integrate-and-comb decimator runs at the modulator clock. A sequencer counts modulator samples and marks each decimation boundary. A small flag unit raises a shared interrupt with an encoded vector that software reads to dispatch.

Software picks the decimation ratio, a preload count, single or continuous operation, the output coding and a settling delay, then sets the start bit. The preload count stretches only the first decimation period, so that several instances started together deliver results staggered in phase. The settling delay holds the interrupt flag back for a number of complete results so that the filter can flush out the input history. In single mode the start bit drops by itself after the first flagged result. Clearing the start bit stops conversion on the next clock edge. The configuration is captured when a start is accepted.

Top module: `sdc_decim_ctrl`

## Requirements
- R1: After reset, result_o is 0x0000, vec_o is 0, and busy_o, ifg_o, ovf_o and irq_o are all low.
- R2: osr_sel_i value s selects a ratio of 32·2^s for s from 0 to 5; any value above 5 selects 1024. With no preload, the first result is written on the ratio-th enabled modulator clock after the edge that accepts the start.
- R3: A preload value P makes the first decimation period ratio+P enabled clocks long. Every later period is exactly ratio clocks.
- R4: With twos_i low (offset binary), a settled result equals the ones-density of the stream times 2^16, saturated at 0xFFFF. All zeros gives 0x0000, alternating bits give 0x8000 and all ones gives 0xFFFF, for every ratio.
- R5: With twos_i high, bit 15 of the offset-binary word is inverted. All ones gives 0x7FFF, alternating bits give 0x0000 and all zeros gives 0x8000.
- R6: In single mode (single_i high), busy_o falls on the same edge that sets ifg_o, and no further result is written afterwards.
- R7: In continuous mode, a new result sets ifg_o every ratio clocks for as long as busy_o stays high.
- R8: A start_clr_i pulse drops busy_o on the next edge, even in the middle of a period. After that, result_o holds its value and no flag is raised.
- R9: A settling value d (0 to 3) suppresses the flag for the first d results after a start, so ifg_o first rises at result d+1.
- R10: A res_rd_i pulse clears ifg_o. A new flagged result in the same cycle wins over the clear.
- R11: A flagged result that arrives while ifg_o is still set and is not being read in that cycle sets ovf_o.
- R12: vec_o reads 0x02 while ovf_o is set, reads 0x04 while only ifg_o is set, and reads 0x00 otherwise. A vec_rd_i pulse clears only the flag the vector reports. irq_o is high while either flag is set.
- R13: A modulator clock with mod_en_i low takes no sample and does not advance the period count, so each disabled clock delays the result by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Sample qualifier for the bitstream |
| bit_i | input | 1 | Modulator bitstream |
| osr_sel_i | input | 3 | Decimation ratio select, 32·2^s |
| preload_i | input | 8 | Extra clocks added to the first period |
| single_i | input | 1 | 1: single conversion, 0: continuous |
| twos_i | input | 1 | 1: two's complement output, 0: offset binary |
| settle_i | input | 2 | Number of results skipped before the first flag |
| start_set_i | input | 1 | Pulse that sets the start bit |
| start_clr_i | input | 1 | Pulse that clears the start bit (has priority) |
| res_rd_i | input | 1 | Result read strobe |
| vec_rd_i | input | 1 | Vector read strobe |
| result_o | output | 16 | Conversion result |
| busy_o | output | 1 | Start bit state |
| ifg_o | output | 1 | Conversion-complete flag |
| ovf_o | output | 1 | Result-overwrite flag |
| vec_o | output | 5 | Interrupt vector code |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench counts clocks to the first flag with a 32 ratio and a preload of 8, and again with the modulator enable held low for a few cycles. A design that stretches every period, or that counts disabled clocks, shows the flag a period early or late. It forces an overwrite and then reads the vector twice, which catches a wrong priority order and a vector read that clears both flags. It checks settled results in both output codings at the smallest, a middle and a clamped ratio, which exposes wrong scaling or a missing saturation at full scale. It also stops a conversion mid-period and runs single mode with a settling delay, which catches a stop bit that waits for the boundary and a single conversion that keeps running.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned VEC_W = 5;
  typedef enum logic [VEC_W-1:0] {
    VEC_NONE = 5'h00,
    VEC_OVF  = 5'h02,
    VEC_RDY  = 5'h04
  } vec_e;
endpackage

// File: rtl/sdc_seq.sv
module sdc_seq #(
  parameter int unsigned LOG_MIN = 5,
  parameter int unsigned N_OSR   = 6,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned DLY_W   = 2,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned CNT_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_set_i,
  input  logic             start_clr_i,
  input  logic             mod_en_i,
  input  logic [SEL_W-1:0] osr_sel_i,
  input  logic [PRE_W-1:0] preload_i,
  input  logic             single_i,
  input  logic             twos_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             run_o,
  output logic             clr_o,
  output logic             samp_o,
  output logic             dump_o,
  output logic             flag_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             twos_o
);
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(N_OSR - 1);

  logic             run_q, first_q, single_q, twos_q;
  logic [CNT_W-1:0] cnt_q, ratio, limit;
  logic [SEL_W-1:0] sel_q, sel_clamp;
  logic [PRE_W-1:0] pre_q;
  logic [DLY_W-1:0] skip_q;
  logic             accept, last;

  assign sel_clamp = (osr_sel_i > SEL_TOP) ? SEL_TOP : osr_sel_i;
  assign ratio     = CNT_W'(1) << (LOG_MIN + 32'(sel_q));
  assign limit     = first_q ? (ratio + CNT_W'(pre_q)) : ratio;
  assign last      = (cnt_q == limit - CNT_W'(1));
  assign accept    = start_set_i & ~run_q & ~start_clr_i;
  assign dump_o    = run_q & mod_en_i & ~start_clr_i & last;
  assign flag_o    = dump_o & (skip_q == '0);
  assign samp_o    = run_q & mod_en_i;
  assign clr_o     = accept;
  assign run_o     = run_q;
  assign sel_o     = sel_q;
  assign twos_o    = twos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      first_q  <= 1'b0;
      single_q <= 1'b0;
      twos_q   <= 1'b0;
      cnt_q    <= '0;
      sel_q    <= '0;
      pre_q    <= '0;
      skip_q   <= '0;
    end else if (accept) begin
      run_q    <= 1'b1;
      first_q  <= 1'b1;
      cnt_q    <= '0;
      skip_q   <= dly_i;
      sel_q    <= sel_clamp;
      pre_q    <= preload_i;
      single_q <= single_i;
      twos_q   <= twos_i;
    end else if (start_clr_i) begin
      run_q <= 1'b0;
    end else if (run_q && mod_en_i) begin
      if (last) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
        if (skip_q != '0) skip_q <= skip_q - DLY_W'(1);
        else if (single_q) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_STOP_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_i |=> !run_q); // R8
  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && single_q) |=> !run_q); // R6
  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < limit)); // R3
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (run_q && cnt_q == '0)); // R2
endmodule

// File: rtl/sdc_cic.sv
module sdc_cic #(
  parameter int unsigned LOG_MIN = 5,
  parameter int unsigned N_OSR   = 6,
  parameter int unsigned ORDER   = 3,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned ACC_W   = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             samp_i,
  input  logic             bit_i,
  input  logic             dump_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_W-1:0] raw_o
);
  logic [ACC_W-1:0] comb_out;
  logic [OUT_W-1:0] cand [N_OSR];
  logic [OUT_W-1:0] raw_q;

  // pipelined integrators: each stage adds the previous stage's register
  for (genvar k = 0; k < ORDER; k++) begin : gen_int
    logic [ACC_W-1:0] acc_q, acc_in;
    if (k == 0) begin : g_src
      assign acc_in = ACC_W'(bit_i);
    end else begin : g_src
      assign acc_in = gen_int[k-1].acc_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (clr_i)  acc_q <= '0;
      else if (samp_i) acc_q <= acc_q + acc_in;
    end
  end

  for (genvar k = 0; k < ORDER; k++) begin : gen_comb
    logic [ACC_W-1:0] hist_q, diff, c_in;
    if (k == 0) begin : g_src
      assign c_in = gen_int[ORDER-1].acc_q;
    end else begin : g_src
      assign c_in = gen_comb[k-1].diff;
    end
    assign diff = c_in - hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q <= '0;
      else if (clr_i)  hist_q <= '0;
      else if (dump_i) hist_q <= c_in;
    end
  end

  assign comb_out = gen_comb[ORDER-1].diff;

  // per-ratio scaling to full scale 2^OUT_W, saturated
  for (genvar s = 0; s < N_OSR; s++) begin : gen_scale
    localparam int unsigned SH = ORDER * (LOG_MIN + s);
    logic [ACC_W-1:0] sh;
    if (SH >= OUT_W) begin : g_r
      assign sh = comb_out >> (SH - OUT_W);
    end else begin : g_l
      assign sh = comb_out << (OUT_W - SH);
    end
    assign cand[s] = (|sh[ACC_W-1:OUT_W]) ? {OUT_W{1'b1}} : sh[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (dump_i) raw_q <= cand[sel_i];
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/sdc_flags.sv
module sdc_flags
  import sdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_i,
  input  logic             res_rd_i,
  input  logic             vec_rd_i,
  output logic             ifg_o,
  output logic             ovf_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             irq_o
);
  logic ifg_q, ovf_q;
  vec_e vec;

  always_comb begin
    if (ovf_q)      vec = VEC_OVF;
    else if (ifg_q) vec = VEC_RDY;
    else            vec = VEC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifg_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (flag_i) ifg_q <= 1'b1;
      else if (res_rd_i || (vec_rd_i && !ovf_q)) ifg_q <= 1'b0;
      if (flag_i && ifg_q && !res_rd_i) ovf_q <= 1'b1;
      else if (vec_rd_i && ovf_q) ovf_q <= 1'b0;
    end
  end

  assign ifg_o = ifg_q;
  assign ovf_o = ovf_q;
  assign vec_o = vec;
  assign irq_o = ifg_q | ovf_q;

  AST_OVF_NEEDS_IFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> ifg_q); // R11
  AST_RD_CLEARS_IFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_rd_i && !flag_i) |=> !ifg_q); // R10
  AST_VEC_KEEPS_IFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && ovf_q && !res_rd_i && !flag_i) |=> (ifg_q == $past(ifg_q))); // R12
  AST_VEC_CLR_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && ovf_q && !flag_i) |=> !ovf_q); // R12
endmodule

// File: rtl/sdc_decim_ctrl.sv
module sdc_decim_ctrl #(
  parameter int unsigned LOG_MIN = 5,
  parameter int unsigned N_OSR   = 6,
  parameter int unsigned ORDER   = 3,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned DLY_W   = 2,
  parameter int unsigned OUT_W   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mod_en_i,
  input  logic                      bit_i,
  input  logic [$clog2(N_OSR)-1:0]  osr_sel_i,
  input  logic [PRE_W-1:0]          preload_i,
  input  logic                      single_i,
  input  logic                      twos_i,
  input  logic [DLY_W-1:0]          settle_i,
  input  logic                      start_set_i,
  input  logic                      start_clr_i,
  input  logic                      res_rd_i,
  input  logic                      vec_rd_i,
  output logic [OUT_W-1:0]          result_o,
  output logic                      busy_o,
  output logic                      ifg_o,
  output logic                      ovf_o,
  output logic [sdc_pkg::VEC_W-1:0] vec_o,
  output logic                      irq_o
);
  localparam int unsigned LOG_MAX = LOG_MIN + N_OSR - 1;
  localparam int unsigned SEL_W   = $clog2(N_OSR);
  localparam int unsigned ACC_W   = ORDER * LOG_MAX + 1;
  localparam int unsigned CNT_W   = $clog2((1 << LOG_MAX) + (1 << PRE_W));

  logic             clr, samp, dump, flag, twos;
  logic [SEL_W-1:0] sel;
  logic [OUT_W-1:0] raw;

  sdc_seq #(
    .LOG_MIN(LOG_MIN), .N_OSR(N_OSR), .PRE_W(PRE_W),
    .DLY_W(DLY_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_set_i, .start_clr_i, .mod_en_i,
    .osr_sel_i, .preload_i, .single_i, .twos_i,
    .dly_i  (settle_i),
    .run_o  (busy_o),
    .clr_o  (clr),
    .samp_o (samp),
    .dump_o (dump),
    .flag_o (flag),
    .sel_o  (sel),
    .twos_o (twos)
  );

  sdc_cic #(
    .LOG_MIN(LOG_MIN), .N_OSR(N_OSR), .ORDER(ORDER),
    .SEL_W(SEL_W), .OUT_W(OUT_W), .ACC_W(ACC_W)
  ) u_cic (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .samp_i (samp),
    .bit_i,
    .dump_i (dump),
    .sel_i  (sel),
    .raw_o  (raw)
  );

  sdc_flags u_flags (
    .clk_i, .rst_ni,
    .flag_i (flag),
    .res_rd_i, .vec_rd_i,
    .ifg_o, .ovf_o, .vec_o, .irq_o
  );

  assign result_o = raw ^ {twos, {(OUT_W-1){1'b0}}};

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_set_i) |=> $stable(result_o)); // R8
  AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_set_i && !ifg_o) |=> !ifg_o); // R8
endmodule

// File: tb/tb_sdc_decim_ctrl.sv
module tb_sdc_decim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b1, bit_s = 1'b0;
  logic [2:0]  osr_sel = '0;
  logic [7:0]  preload = '0;
  logic        single = 1'b0, twos = 1'b0;
  logic [1:0]  settle = '0;
  logic        start_set = 1'b0, start_clr = 1'b0, res_rd = 1'b0, vec_rd = 1'b0;
  logic [15:0] result;
  logic        busy, ifg, ovf, irq;
  logic [4:0]  vec;
  int          n_tests = 0, n_fail = 0;
  int          pat = 0;

  always #4 clk = ~clk;

  sdc_decim_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .bit_i(bit_s),
    .osr_sel_i(osr_sel), .preload_i(preload), .single_i(single), .twos_i(twos),
    .settle_i(settle), .start_set_i(start_set), .start_clr_i(start_clr),
    .res_rd_i(res_rd), .vec_rd_i(vec_rd), .result_o(result), .busy_o(busy),
    .ifg_o(ifg), .ovf_o(ovf), .vec_o(vec), .irq_o(irq)
  );

  // 0: zeros, 1: ones, 2: alternating
  initial forever begin
    @(negedge clk);
    case (pat)
      0:       bit_s = 1'b0;
      1:       bit_s = 1'b1;
      default: bit_s = ~bit_s;
    endcase
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mod_en = 1'b1; osr_sel = '0; preload = '0; single = 1'b0;
    twos = 1'b0; settle = '0; start_set = 1'b0; start_clr = 1'b0;
    res_rd = 1'b0; vec_rd = 1'b0; pat = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // leaves the bench at the negedge after the accepting edge
  task automatic start_conv();
    start_set = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_set = 1'b0;
  endtask

  task automatic pulse_res();
    res_rd = 1'b1; @(posedge clk); @(negedge clk); res_rd = 1'b0;
  endtask

  task automatic pulse_vec();
    vec_rd = 1'b1; @(posedge clk); @(negedge clk); vec_rd = 1'b0;
  endtask

  task automatic expect_rise(string req, int m);
    repeat (m - 1) @(posedge clk);
    @(negedge clk);
    chk(req, "ifg before boundary", 32'(ifg), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(req, "ifg at boundary", 32'(ifg), 32'd1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "result", 32'(result), 32'h0);
    chk("R1", "flags busy/ifg/ovf/irq", {28'd0, busy, ifg, ovf, irq}, 32'h0);
    chk("R1", "vec", 32'(vec), 32'h0);
  endtask

  task automatic t_preload();
    do_reset();
    pat = 1; osr_sel = 3'd0; preload = 8'd8;
    start_conv();
    expect_rise("R3", 40);
    pulse_res();
    chk("R10", "ifg after read", 32'(ifg), 32'd0);
    expect_rise("R7", 31);
  endtask

  task automatic t_ratio_clamp();
    do_reset();
    osr_sel = 3'd7;
    start_conv();
    expect_rise("R2", 1024);
  endtask

  task automatic t_level(int sel, int p, bit tc, logic [15:0] exp, string req);
    do_reset();
    pat = p; osr_sel = 3'(sel); twos = tc;
    start_conv();
    repeat ((6 << (5 + sel)) + 2) @(posedge clk);
    @(negedge clk);
    chk(req, $sformatf("settled word sel=%0d pat=%0d", sel, p), 32'(result), 32'(exp));
  endtask

  task automatic t_single();
    do_reset();
    pat = 2; single = 1'b1;
    start_conv();
    repeat (31) @(posedge clk);
    @(negedge clk);
    chk("R6", "busy before result", 32'(busy), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "busy after result", 32'(busy), 32'd0);
    chk("R6", "ifg after result", 32'(ifg), 32'd1);
    pulse_res();
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R6", "no second result", 32'(ifg), 32'd0);
  endtask

  task automatic t_stop();
    logic [15:0] held;
    do_reset();
    pat = 2;
    start_conv();
    repeat (106) @(posedge clk);
    @(negedge clk);
    res_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_rd = 1'b0; start_clr = 1'b1;
    held = result;
    @(posedge clk);
    @(negedge clk);
    start_clr = 1'b0;
    chk("R8", "busy after clear", 32'(busy), 32'd0);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R8", "no flag after stop", 32'(ifg), 32'd0);
    chk("R8", "result held", 32'(result), 32'(held));
  endtask

  task automatic t_settle();
    do_reset();
    settle = 2'd2;
    start_conv();
    expect_rise("R9", 96);
  endtask

  task automatic t_ovf_vec();
    do_reset();
    start_conv();
    expect_rise("R2", 32);
    chk("R12", "vec conv only", 32'(vec), 32'h04);
    repeat (32) @(posedge clk);
    @(negedge clk);
    chk("R11", "ovf on overwrite", 32'(ovf), 32'd1);
    chk("R12", "vec overflow first", 32'(vec), 32'h02);
    chk("R12", "irq", 32'(irq), 32'd1);
    pulse_vec();
    chk("R12", "ovf cleared", 32'(ovf), 32'd0);
    chk("R12", "ifg kept", 32'(ifg), 32'd1);
    chk("R12", "vec conv", 32'(vec), 32'h04);
    pulse_vec();
    chk("R12", "vec none", 32'(vec), 32'h00);
    chk("R12", "irq low", 32'(irq), 32'd0);
  endtask

  task automatic t_enable();
    do_reset();
    start_conv();
    mod_en = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    mod_en = 1'b1;
    expect_rise("R13", 32);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_preload();
    t_ratio_clamp();
    t_level(0, 1, 1'b0, 16'hFFFF, "R4");
    t_level(1, 2, 1'b0, 16'h8000, "R4");
    t_level(0, 0, 1'b0, 16'h0000, "R4");
    t_level(5, 2, 1'b0, 16'h8000, "R4");
    t_level(0, 1, 1'b1, 16'h7FFF, "R5");
    t_level(1, 2, 1'b1, 16'h0000, "R5");
    t_level(0, 0, 1'b1, 16'h8000, "R5");
    t_single();
    t_stop();
    t_settle();
    t_ovf_vec();
    t_enable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule